// File: doc/BRIEF.md
# Time-Shared Redundant Check for Four Booth Multipliers

This block contains four independent signed radix-4 Booth multipliers. Each one has its own pair of 4-bit operands. All four are guarded by one redundancy checker that they share. A rotating 2-bit select value chooses one unit per clock. The operands of that unit are steered to two spare Booth multipliers. The tested unit's product and the two spare products are captured in registers, and a bitwise 2-of-3 majority is then formed from the three captured values.

When the tested unit's captured product differs from the majority, the majority value is driven on that unit's output and the unit's error flag is raised. The other three units pass their captured products through unchanged. A second flag shows when the two spare units disagree with each other. The spares and the four main units have stuck-at fault inputs for test, which can force any chosen product bits to a chosen level.

All outputs come from registers, so a result appears one clock after its operands are presented. The operands, the select value and the four main products are captured together. This means the correction is always written to the unit whose product was actually voted on.

Top module: `rot_tmr_mul`

## Requirements
- R1: While `rst_n` is low, all registers clear asynchronously. `prod_o`, `unit_err_o` and `spare_err_o` then read zero.
- R2: With no fault forced, each output slice `prod_o[8k+7:8k]` equals the signed two's-complement product of `mcand_i[4k+3:4k]` and `mplier_i[4k+3:4k]`, one rising clock edge after they were presented.
- R3: At the first rising edge after reset release, unit 0 is captured for test. Each later edge captures unit 1, 2, 3, then 0 again, and so on.
- R4: If the tested unit's product is corrupted and both spares agree, that unit's output shows the fault-free product.
- R5: A unit that is not under test shows its own captured product, corrupted or not, and its error flag stays low.
- R6: `unit_err_o[k]` is high only when unit k is the tested unit and its captured product differs from the bitwise majority. At most one bit is high.
- R7: `spare_err_o` is high exactly when the two captured spare products differ.
- R8: Stuck-at encoding for main unit k: each bit set in `flt_mask_i[8k+7:8k]` forces the same product bit to `flt_pol_i[k]` (0 = stuck low, 1 = stuck high). Spare j uses `spr_flt_mask_i[8j+7:8j]` and `spr_flt_pol_i[j]` in the same way.
- R9: A fault on only one spare leaves every output and every `unit_err_o` bit at its fault-free value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcand_i | input | 16 | Multiplicands, 4 bits per unit, unit 0 in the low bits |
| mplier_i | input | 16 | Multipliers, 4 bits per unit |
| flt_mask_i | input | 32 | Stuck-at bit mask for each main unit's product |
| flt_pol_i | input | 4 | Stuck-at level for each main unit |
| spr_flt_mask_i | input | 16 | Stuck-at bit mask for each spare's product |
| spr_flt_pol_i | input | 2 | Stuck-at level for each spare |
| prod_o | output | 32 | Corrected products, 8 bits per unit |
| unit_err_o | output | 4 | Tested unit disagreed with the majority |
| spare_err_o | output | 1 | The two spare products differ |

## Verification
The masking property assumes at most one of the three voted products is corrupted in a cycle. If two corruptions agreed, the majority itself would be wrong. The stimulus therefore forces a fault on only one main unit at a time, or on only one spare, and never on both at once. Operands sweep every 4-bit pair on each unit, and the unit offsets are staggered so that every unit is tested with many distinct values. The bench computes each expected product arithmetically.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int unsigned UNITS_DEF = 4;
  localparam int unsigned OPW_DEF   = 4;
  localparam int unsigned SPARES    = 2;

  typedef enum logic {
    STUCK_LO = 1'b0,
    STUCK_HI = 1'b1
  } stuck_pol_e;
endpackage

// File: rtl/booth_r4_mul.sv
module booth_r4_mul #(
  parameter int unsigned OPW = 4
) (
  input  logic [OPW-1:0]   mcand,
  input  logic [OPW-1:0]   mplier,
  output logic [2*OPW-1:0] prod
);
  localparam int unsigned PW   = 2 * OPW;
  localparam int unsigned NDIG = OPW / 2;

  logic [OPW:0]    bx;
  logic [PW-1:0]   ext;
  logic [PW-1:0]   pps [NDIG];

  assign bx  = {mplier, 1'b0};
  assign ext = {{OPW{mcand[OPW-1]}}, mcand};

  // one recoded digit in -2..+2 per pair of multiplier bits
  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [2:0]    trip;
    logic [PW-1:0] pp;
    assign trip = bx[2*g+2 : 2*g];
    always_comb begin
      unique case (trip)
        3'b001, 3'b010: pp = ext;
        3'b011:         pp = ext << 1;
        3'b100:         pp = -(ext << 1);
        3'b101, 3'b110: pp = -ext;
        default:        pp = '0;
      endcase
    end
    assign pps[g] = pp << (2 * g);
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < NDIG; i++) prod = prod + pps[i];
  end

  logic signed [PW-1:0] ref_a, ref_b;
  assign ref_a = $signed({{OPW{mcand[OPW-1]}}, mcand});
  assign ref_b = $signed({{OPW{mplier[OPW-1]}}, mplier});

  always_comb begin
    assert_booth_exact_R2: assert (prod == PW'(ref_a * ref_b))
      else $error("booth recode sum mismatch");
  end
endmodule

// File: rtl/stuck_fault.sv
module stuck_fault
  import rtmr_pkg::*;
#(
  parameter int unsigned PW = 8
) (
  input  logic [PW-1:0] din,
  input  logic [PW-1:0] mask,
  input  stuck_pol_e    pol,
  output logic [PW-1:0] dout
);
  logic [PW-1:0] lvl;
  assign lvl  = (pol == STUCK_HI) ? {PW{1'b1}} : {PW{1'b0}};
  assign dout = (din & ~mask) | (mask & lvl);
endmodule

// File: rtl/maj_voter.sv
module maj_voter #(
  parameter int unsigned PW = 8
) (
  input  logic [PW-1:0] main_p,
  input  logic [PW-1:0] spa_p,
  input  logic [PW-1:0] spb_p,
  output logic [PW-1:0] vote,
  output logic          main_bad,
  output logic          spare_diff
);
  assign vote       = (main_p & spa_p) | (main_p & spb_p) | (spa_p & spb_p);
  assign main_bad   = (main_p != vote);
  assign spare_diff = (spa_p != spb_p);
endmodule

// File: rtl/rot_tmr_mul.sv
module rot_tmr_mul
  import rtmr_pkg::*;
#(
  parameter int unsigned NUNIT = UNITS_DEF,
  parameter int unsigned OPW   = OPW_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUNIT*OPW-1:0]    mcand_i,
  input  logic [NUNIT*OPW-1:0]    mplier_i,
  input  logic [NUNIT*2*OPW-1:0]  flt_mask_i,
  input  logic [NUNIT-1:0]        flt_pol_i,
  input  logic [SPARES*2*OPW-1:0] spr_flt_mask_i,
  input  logic [SPARES-1:0]       spr_flt_pol_i,
  output logic [NUNIT*2*OPW-1:0]  prod_o,
  output logic [NUNIT-1:0]        unit_err_o,
  output logic                    spare_err_o
);
  localparam int unsigned PW   = 2 * OPW;
  localparam int unsigned SELW = (NUNIT > 1) ? $clog2(NUNIT) : 1;

  logic [SELW-1:0] cnt_q, cnt_d;
  logic [SELW-1:0] tst_sel_q, tst_sel_d;
  logic [PW-1:0]   main_raw  [NUNIT];
  logic [PW-1:0]   main_d    [NUNIT];
  logic [PW-1:0]   main_q    [NUNIT];
  logic [PW-1:0]   spare_d   [SPARES];
  logic [PW-1:0]   spare_q   [SPARES];
  logic [PW-1:0]   corr      [NUNIT];
  logic [OPW-1:0]  sel_mc, sel_mp;
  logic [PW-1:0]   tst_main, vote;
  logic            main_bad, spare_diff;

  // main units with fault injection on their products
  for (genvar k = 0; k < NUNIT; k++) begin : g_main
    booth_r4_mul #(.OPW(OPW)) u_mul (
      .mcand (mcand_i[k*OPW +: OPW]),
      .mplier(mplier_i[k*OPW +: OPW]),
      .prod  (main_raw[k])
    );
    stuck_fault #(.PW(PW)) u_flt (
      .din (main_raw[k]),
      .mask(flt_mask_i[k*PW +: PW]),
      .pol (stuck_pol_e'(flt_pol_i[k])),
      .dout(main_d[k])
    );
  end

  // operand steering to the spares
  assign sel_mc = mcand_i[cnt_q*OPW +: OPW];
  assign sel_mp = mplier_i[cnt_q*OPW +: OPW];

  for (genvar j = 0; j < SPARES; j++) begin : g_spare
    logic [PW-1:0] sp_raw;
    booth_r4_mul #(.OPW(OPW)) u_mul (
      .mcand (sel_mc),
      .mplier(sel_mp),
      .prod  (sp_raw)
    );
    stuck_fault #(.PW(PW)) u_flt (
      .din (sp_raw),
      .mask(spr_flt_mask_i[j*PW +: PW]),
      .pol (stuck_pol_e'(spr_flt_pol_i[j])),
      .dout(spare_d[j])
    );
  end

  // next state
  always_comb begin
    cnt_d     = (cnt_q == SELW'(NUNIT - 1)) ? '0 : cnt_q + 1'b1;
    tst_sel_d = cnt_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      tst_sel_q <= '0;
      for (int k = 0; k < NUNIT; k++) main_q[k] <= '0;
      for (int j = 0; j < SPARES; j++) spare_q[j] <= '0;
    end else begin
      cnt_q     <= cnt_d;
      tst_sel_q <= tst_sel_d;
      for (int k = 0; k < NUNIT; k++) main_q[k] <= main_d[k];
      for (int j = 0; j < SPARES; j++) spare_q[j] <= spare_d[j];
    end
  end

  // vote on the captured tested product
  assign tst_main = main_q[tst_sel_q];

  maj_voter #(.PW(PW)) u_vote (
    .main_p    (tst_main),
    .spa_p     (spare_q[0]),
    .spb_p     (spare_q[1]),
    .vote      (vote),
    .main_bad  (main_bad),
    .spare_diff(spare_diff)
  );

  // replace stage
  for (genvar k = 0; k < NUNIT; k++) begin : g_repl
    logic hit;
    assign hit               = (tst_sel_q == SELW'(k)) && main_bad;
    assign corr[k]           = hit ? vote : main_q[k];
    assign prod_o[k*PW +: PW] = corr[k];
    assign unit_err_o[k]     = hit;
  end
  assign spare_err_o = spare_diff;

  // checks
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (prod_o == '0 && unit_err_o == '0 && !spare_err_o))
    else $error("outputs not clear in reset");

  assert_sel_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tst_sel_q == $past(cnt_q))
    else $error("tested select not taken from rotation");

  assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_q[0] == spare_q[1]) |-> corr[tst_sel_q] == spare_q[0])
    else $error("agreeing spares not driven on tested output");

  assert_err_tested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_err_o != '0) |-> (unit_err_o[tst_sel_q] && $onehot0(unit_err_o)))
    else $error("error flag on an untested unit");

  assert_spare_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spare_err_o |-> (spare_q[0] != spare_q[1]))
    else $error("spare flag with agreeing spares");
endmodule

// File: tb/rot_tmr_mul_test.sv
module rot_tmr_mul_test;
  localparam int N   = 4;
  localparam int OPW = 4;
  localparam int PW  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N*OPW-1:0] mcand_i = '0, mplier_i = '0;
  logic [N*PW-1:0]  flt_mask_i = '0;
  logic [N-1:0]     flt_pol_i = '0;
  logic [2*PW-1:0]  spr_flt_mask_i = '0;
  logic [1:0]       spr_flt_pol_i = '0;
  logic [N*PW-1:0]  prod_o;
  logic [N-1:0]     unit_err_o;
  logic             spare_err_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int edges = 0;

  always #2 clk = ~clk;

  rot_tmr_mul uut (
    .clk(clk), .rst_n(rst_n), .mcand_i(mcand_i), .mplier_i(mplier_i),
    .flt_mask_i(flt_mask_i), .flt_pol_i(flt_pol_i),
    .spr_flt_mask_i(spr_flt_mask_i), .spr_flt_pol_i(spr_flt_pol_i),
    .prod_o(prod_o), .unit_err_o(unit_err_o), .spare_err_o(spare_err_o)
  );

  always @(posedge clk) begin
    edges++;
    if (edges > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d edges expected<=100000", edges);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] smul(logic [3:0] a, logic [3:0] b);
    int sa, sb;
    sa = int'($signed(a));
    sb = int'($signed(b));
    return 8'(sa * sb);
  endfunction

  function automatic logic [7:0] stuck(logic [7:0] v, logic [7:0] m, logic p);
    return (v & ~m) | (m & {8{p}});
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle of operands, then check the registered result
  task automatic step(string tprod, string terr);
    logic [7:0]  tru [N];
    logic [7:0]  flt [N];
    logic [7:0]  sp0, sp1, vt;
    logic [31:0] ep;
    logic [3:0]  ee;
    int          tst;
    tst = cyc % N;
    for (int k = 0; k < N; k++) begin
      tru[k] = smul(mcand_i[k*4 +: 4], mplier_i[k*4 +: 4]);
      flt[k] = stuck(tru[k], flt_mask_i[k*8 +: 8], flt_pol_i[k]);
    end
    sp0 = stuck(tru[tst], spr_flt_mask_i[7:0],  spr_flt_pol_i[0]);
    sp1 = stuck(tru[tst], spr_flt_mask_i[15:8], spr_flt_pol_i[1]);
    vt  = (flt[tst] & sp0) | (flt[tst] & sp1) | (sp0 & sp1);
    ee  = '0;
    for (int k = 0; k < N; k++) ep[k*8 +: 8] = flt[k];
    if (flt[tst] != vt) begin
      ep[tst*8 +: 8] = vt;
      ee[tst] = 1'b1;
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    chk(prod_o == ep, tprod, prod_o, ep);
    chk(unit_err_o == ee, terr, {28'd0, unit_err_o}, {28'd0, ee});
    chk(spare_err_o == (sp0 != sp1), "R7 spare flag", {31'd0, spare_err_o},
        {31'd0, sp0 != sp1});
  endtask

  task automatic set_ops(int i);
    for (int k = 0; k < N; k++) begin
      logic [7:0] p;
      p = 8'((i + 64 * k + 13 * k) & 255);
      mcand_i[k*4 +: 4]  = p[3:0];
      mplier_i[k*4 +: 4] = p[7:4];
    end
  endtask

  initial begin
    logic [7:0] masks [4];
    masks[0] = 8'h01; masks[1] = 8'h80; masks[2] = 8'hF0; masks[3] = 8'h5A;

    // R1: reset holds everything at zero with operands active
    set_ops(77);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(prod_o == '0, "R1 prod in reset", prod_o, 32'd0);
    chk(unit_err_o == '0 && !spare_err_o, "R1 flags in reset",
        {27'd0, unit_err_o, spare_err_o}, 32'd0);
    rst_n = 1'b1;
    #1;
    chk(prod_o == '0, "R1 prod before first edge", prod_o, 32'd0);
    cyc = 0;

    // R2: every operand pair on every unit, no faults
    for (int i = 0; i < 256; i++) begin
      set_ops(i);
      step("R2 clean product", "R6 clean flags");
    end

    // R4 R5 R8 R3 R6: one stuck main unit at a time
    for (int k = 0; k < N; k++)
      for (int pl = 0; pl < 2; pl++)
        for (int m = 0; m < 4; m++) begin
          flt_mask_i = '0;
          flt_mask_i[k*8 +: 8] = masks[m];
          flt_pol_i = '0;
          flt_pol_i[k] = pl[0];
          for (int i = 0; i < 8; i++) begin
            int tst;
            tst = cyc % N;
            set_ops(i * 29 + m * 7 + k);
            step("R4/R5/R8 main fault", "R6 main fault flag");
            // R3: flag position follows the rotation when the fault shows
            if (unit_err_o != '0)
              chk(unit_err_o == 4'(1 << tst), "R3 rotation", {28'd0, unit_err_o},
                  32'(1 << tst));
          end
        end
    flt_mask_i = '0;
    flt_pol_i  = '0;

    // R9 R7: a single stuck spare
    for (int j = 0; j < 2; j++)
      for (int pl = 0; pl < 2; pl++)
        for (int m = 0; m < 4; m++) begin
          spr_flt_mask_i = '0;
          spr_flt_mask_i[j*8 +: 8] = masks[m];
          spr_flt_pol_i = '0;
          spr_flt_pol_i[j] = pl[0];
          for (int i = 0; i < 8; i++) begin
            set_ops(i * 41 + m + j * 5);
            step("R9 spare fault outputs", "R9 spare fault unit flags");
          end
        end
    spr_flt_mask_i = '0;
    spr_flt_pol_i  = '0;

    // R1: asynchronous reset mid-run, then rotation restarts at unit 0 (R3)
    set_ops(5);
    #1 rst_n = 1'b0;
    #1;
    chk(prod_o == '0, "R1 async clear", prod_o, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    flt_mask_i[7:0] = 8'hFF;
    flt_pol_i[0] = 1'b0;
    mcand_i[3:0] = 4'd3; mplier_i[3:0] = 4'd5;
    step("R3 restart at unit 0", "R3 restart flag");
    chk(unit_err_o == 4'b0001, "R3 unit 0 first", {28'd0, unit_err_o}, 32'd1);
    flt_mask_i = '0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule